// File: doc/BRIEF.md
# PLL Control Register and Lock Timer

This block holds the control state of a programmable PLL behind a small register port and emulates its lock detection with a cycle counter. Software first writes a lock duration, counted in reference-clock cycles, and then a control word. The control word carries an enable bit and the feedback, pre-divider and post-divider settings (M, P, S). The divider fields are driven straight out to downstream logic, which takes them as the frequency code.

Each control write with enable set drops the locked flag, takes a copy of the programmed lock duration and starts counting reference cycles. When the count reaches that duration, the flag is raised. Software polls the locked bit in the control word and relies on the new output only once that bit reads 1. With enable clear, the flag stays low and the counter is held.

The register port has no handshake. A write is taken on the rising edge where `wr_en` is high. Reads are combinational from `rd_addr` and show the register state in the same cycle. All state is reset by the active-low `rst_n`.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, both registers read zero, `pll_locked` is 0, and `pll_en`, `pll_m`, `pll_p` and `pll_s` are all zero.
- R2: Address 0 holds the lock duration. It is 16 bits wide and occupies bits 15:0. Read-data bits 31:16 at this address are always zero, whatever was written.
- R3: Address 1 holds the control word. Its layout is: enable at bit 31, locked status at bit 29 (read only), M at bits 25:16, P at bits 13:8 and S at bits 2:0. Every other bit, and a written bit 29, has no effect and reads back as zero.
- R4: `pll_en`, `pll_m`, `pll_p` and `pll_s` show the written control fields from the rising edge that takes the write.
- R5: A control write with enable set clears `pll_locked` on its own edge. `pll_locked` rises on the N-th rising edge after that edge, where N is the lock duration held when the write was taken.
- R6: A write to the lock-duration register while a lock count is running does not change the duration of that count.
- R7: A control write with enable set while already locked clears the flag and restarts the count from zero.
- R8: A control write with enable clear drops `pll_locked` on its own edge. The flag then stays 0 for as long as enable remains clear.
- R9: Reads of addresses 2 and 3 return zero. Writes to them change neither register.
- R10: A lock duration of 0 behaves as 1: the flag rises on the first edge after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| pll_en | output | 1 | PLL enable from the control word |
| pll_m | output | 10 | Feedback divider M |
| pll_p | output | 6 | Pre-divider P |
| pll_s | output | 3 | Post-divider S |
| pll_locked | output | 1 | Lock flag |

## Verification
The lock timer is exercised with durations of 5, 100 and 0. The bench reads the flag on every cycle around the expected rise, which separates an off-by-one in the counter from a correct count. A duration rewrite in the middle of a count, followed by a relock, shows that the duration is sampled at the control write and not compared live. Control writes that set reserved and status bits, writes with enable clear and writes to unmapped addresses check that only the defined fields reach the register and the outputs.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned EN_POS   = 31;
  localparam int unsigned LOCK_POS = 29;
  localparam int unsigned M_POS    = 16;
  localparam int unsigned P_POS    = 8;
  localparam int unsigned S_POS    = 0;

  localparam logic [1:0] ADR_LOCKTIME = 2'd0;
  localparam logic [1:0] ADR_CTRL     = 2'd1;
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
  import pllc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LOCK_W = 16,
  parameter int unsigned M_W    = 10,
  parameter int unsigned P_W    = 6,
  parameter int unsigned S_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [LOCK_W-1:0] lock_time_o,
  output logic              en_o,
  output logic [M_W-1:0]    m_o,
  output logic [P_W-1:0]    p_o,
  output logic [S_W-1:0]    s_o,
  output logic              ctrl_wr_o,
  output logic              ctrl_wr_en_o
);
  logic sel_lt, sel_ctrl;

  assign sel_lt       = wr_en_i && (wr_addr_i == ADDR_W'(ADR_LOCKTIME));
  assign sel_ctrl     = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
  assign ctrl_wr_o    = sel_ctrl;
  assign ctrl_wr_en_o = wr_data_i[EN_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_time_o <= '0;
      en_o        <= 1'b0;
      m_o         <= '0;
      p_o         <= '0;
      s_o         <= '0;
    end else begin
      if (sel_lt) lock_time_o <= wr_data_i[LOCK_W-1:0];
      if (sel_ctrl) begin
        en_o <= wr_data_i[EN_POS];
        m_o  <= wr_data_i[M_POS +: M_W];
        p_o  <= wr_data_i[P_POS +: P_W];
        s_o  <= wr_data_i[S_POS +: S_W];
      end
    end
  end

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i > ADDR_W'(ADR_CTRL)) |=>
      ($stable(lock_time_o) && $stable(en_o) && $stable(m_o)));

  // R4
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> (en_o == $past(wr_data_i[EN_POS])));
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_wr_en_i,
  input  logic [LOCK_W-1:0] lock_time_i,
  output logic              locked_o
);
  logic [LOCK_W-1:0] cnt_q;
  logic [LOCK_W-1:0] snap_q;
  logic [LOCK_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      snap_q   <= '0;
      locked_o <= 1'b0;
    end else if (ctrl_wr_i) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
      if (ctrl_wr_en_i) snap_q <= lock_time_i;
    end else if (!en_i) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (!locked_o) begin
      cnt_q <= cnt_nxt[LOCK_W-1:0];
      if (cnt_nxt >= {1'b0, snap_q}) locked_o <= 1'b1;
    end
  end

  // R5
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> !locked_o);

  // R8
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ctrl_wr_i) |=> !locked_o);

  // R5
  rise_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($past(en_i) && !$past(ctrl_wr_i)));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_i |=> $stable(snap_q));
endmodule

// File: rtl/pllc_rdmux.sv
module pllc_rdmux
  import pllc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LOCK_W = 16,
  parameter int unsigned M_W    = 10,
  parameter int unsigned P_W    = 6,
  parameter int unsigned S_W    = 3
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [LOCK_W-1:0] lock_time_i,
  input  logic              en_i,
  input  logic              locked_i,
  input  logic [M_W-1:0]    m_i,
  input  logic [P_W-1:0]    p_i,
  input  logic [S_W-1:0]    s_i,
  output logic [WORD_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADR_LOCKTIME)) begin
      rd_data_o[LOCK_W-1:0] = lock_time_i;
    end else if (rd_addr_i == ADDR_W'(ADR_CTRL)) begin
      rd_data_o[EN_POS]         = en_i;
      rd_data_o[LOCK_POS]       = locked_i;
      rd_data_o[M_POS +: M_W]   = m_i;
      rd_data_o[P_POS +: P_W]   = p_i;
      rd_data_o[S_POS +: S_W]   = s_i;
    end
  end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pllc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned LOCK_W = 16,
  parameter int unsigned M_W    = 10,
  parameter int unsigned P_W    = 6,
  parameter int unsigned S_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              pll_en,
  output logic [M_W-1:0]    pll_m,
  output logic [P_W-1:0]    pll_p,
  output logic [S_W-1:0]    pll_s,
  output logic              pll_locked
);
  logic [LOCK_W-1:0] lock_time;
  logic              ctrl_wr;
  logic              ctrl_wr_en;

  pllc_regs #(
    .ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .M_W(M_W), .P_W(P_W), .S_W(S_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .lock_time_o(lock_time), .en_o(pll_en),
    .m_o(pll_m), .p_o(pll_p), .s_o(pll_s),
    .ctrl_wr_o(ctrl_wr), .ctrl_wr_en_o(ctrl_wr_en)
  );

  pllc_lock_timer #(.LOCK_W(LOCK_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .en_i(pll_en), .ctrl_wr_i(ctrl_wr), .ctrl_wr_en_i(ctrl_wr_en),
    .lock_time_i(lock_time), .locked_o(pll_locked)
  );

  pllc_rdmux #(
    .ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .M_W(M_W), .P_W(P_W), .S_W(S_W)
  ) u_rdmux (
    .rd_addr_i(rd_addr), .lock_time_i(lock_time), .en_i(pll_en),
    .locked_i(pll_locked), .m_i(pll_m), .p_i(pll_p), .s_i(pll_s),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/pll_lock_ctrl_bench.sv
module pll_lock_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pll_en;
  logic [9:0]  pll_m;
  logic [5:0]  pll_p;
  logic [2:0]  pll_s;
  logic        pll_locked;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  rd_req = 1'b0;

  typedef struct {
    logic [31:0] exp_data;
    logic        exp_lock;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #4 clk = ~clk;

  pll_lock_ctrl u_pll_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pll_en(pll_en), .pll_m(pll_m), .pll_p(pll_p), .pll_s(pll_s),
    .pll_locked(pll_locked)
  );

  function automatic logic [31:0] cw(input logic en, input logic lk,
      input int m, input int p, input int s);
    logic [31:0] w;
    w = '0;
    w[31] = en; w[29] = lk;
    w[25:16] = 10'(m); w[13:8] = 6'(p); w[2:0] = 3'(s);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard and compares while a read is pending
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rd_req && sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        chk({it.tag, " rd_data"}, rd_data, it.exp_data);
        chk({it.tag, " locked"}, {31'b0, pll_locked}, {31'b0, it.exp_lock});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp,
      input logic lk, input string tag);
    sb_item_t it;
    it.exp_data = exp; it.exp_lock = lk; it.tag = tag;
    rd_addr = a;
    sbq.push_back(it);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, 32'h0, 1'b0, "R1 ctrl");
    rd(2'd0, 32'h0, 1'b0, "R1 locktime");
    chk("R1 outputs", {19'b0, pll_en, pll_m, pll_p, pll_s}, 32'h0);

    // R2 lock register width
    wr(2'd0, 32'h0000_02CF);
    rd(2'd0, 32'h0000_02CF, 1'b0, "R2 locktime 2cf");
    wr(2'd0, 32'hFFFF_0005);
    rd(2'd0, 32'h0000_0005, 1'b0, "R2 upper zero");

    // R3 R4 R5: 1000 MHz setting with reserved and status bits set
    wr(2'd1, 32'h8000_0000 | (125 << 16) | (3 << 8) | 1 | 32'h7C00_C0F8);
    chk("R4 ports", {19'b0, pll_en, pll_m, pll_p, pll_s},
        {19'b0, 1'b1, 10'd125, 6'd3, 3'd1});
    for (int off = 0; off <= 5; off++)
      rd(2'd1, cw(1'b1, off >= 5, 125, 3, 1), off >= 5, "R5 R3 lock timing");

    // R6 rewrite of duration during a count
    wr(2'd1, cw(1'b1, 1'b0, 125, 3, 1));
    wr(2'd0, 32'd100);
    idle(3);
    rd(2'd1, cw(1'b1, 1'b0, 125, 3, 1), 1'b0, "R6 before");
    rd(2'd1, cw(1'b1, 1'b1, 125, 3, 1), 1'b1, "R6 old duration kept");

    // R7 relock at 800 MHz while locked, new duration 100
    wr(2'd1, cw(1'b1, 1'b0, 100, 3, 1));
    chk("R7 m port", {22'b0, pll_m}, 32'd100);
    rd(2'd1, cw(1'b1, 1'b0, 100, 3, 1), 1'b0, "R7 cleared");
    idle(98);
    rd(2'd1, cw(1'b1, 1'b0, 100, 3, 1), 1'b0, "R7 edge 99");
    rd(2'd1, cw(1'b1, 1'b1, 100, 3, 1), 1'b1, "R7 edge 100");

    // R8 disable
    wr(2'd1, cw(1'b0, 1'b0, 100, 3, 1));
    rd(2'd1, cw(1'b0, 1'b0, 100, 3, 1), 1'b0, "R8 dropped");
    idle(120);
    rd(2'd1, cw(1'b0, 1'b0, 100, 3, 1), 1'b0, "R8 held");
    chk("R8 en port", {31'b0, pll_en}, 32'h0);

    // R9 unmapped addresses
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0, 1'b0, "R9 addr2");
    rd(2'd3, 32'h0, 1'b0, "R9 addr3");
    rd(2'd0, 32'd100, 1'b0, "R9 locktime kept");
    rd(2'd1, cw(1'b0, 1'b0, 100, 3, 1), 1'b0, "R9 ctrl kept");

    // R10 zero duration
    wr(2'd0, 32'd0);
    wr(2'd1, cw(1'b1, 1'b0, 7, 2, 4));
    rd(2'd1, cw(1'b1, 1'b0, 7, 2, 4), 1'b0, "R10 write edge");
    rd(2'd1, cw(1'b1, 1'b1, 7, 2, 4), 1'b1, "R10 next edge");

    idle(2);
    chk("scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule